// File: doc/BRIEF.md
# Two-Way Write-Through Cache Controller

This block sits between a 32-bit processor core and main memory and caches a 27-bit byte address space in two ways with four-word lines. The capacity is fixed at elaboration to 4KB or 2KB. The core issues single-word reads and writes. A read that hits returns data one cycle after the request. A read that misses fetches the whole line from memory, one word at a time, into the way chosen for replacement, and then returns the requested word. Every write goes straight to memory. A write that hits also updates the cached copy. A write that misses leaves the cache unchanged.

Each line index has a single 2-bit status code that covers both ways. That one code says which ways hold valid data, which way was used most recently (and so which way is replaced next), and together with the tag compare it selects the way that returns data. A one-cycle invalidate input empties the whole cache.

The core holds no request open. It pulses `cpu_req` for one cycle and waits for the one-cycle `cpu_done` pulse before it issues the next request. The memory port holds `mem_req` and its address steady until `mem_ack`, and each `mem_ack` carries one word.

Top module: `cache2w_top`

## Requirements
- R1: After reset every line is invalid: `cpu_done` and `mem_req` are low, `cpu_rdata` is zero, and the first read of any address is a miss.
- R2: A read hit asserts `cpu_done` in the cycle after `cpu_req`, with the word of the matching way on `cpu_rdata` and no memory request.
- R3: A read miss issues four memory reads of the line. The reads go to address bits [3:2] = 0, 1, 2, 3 in that order, with bits [1:0] zero. Each read holds `mem_req` and `mem_addr` until `mem_ack`. `cpu_done` comes in the cycle after the fourth acknowledge and carries the word selected by bits [3:2] of the request.
- R4: With SIZE_KB=4 the line index is address bits [10:4] and the tag is bits [26:11]. With SIZE_KB=2 the index is bits [9:4] and the tag is bits [26:10]. Addresses whose index differs occupy separate lines.
- R5: Status codes: 00 means both ways are invalid, 01 means only way 0 is valid, 11 means both are valid with way 1 used last, and 10 means both are valid with way 0 used last. Any access to way 1 sets 11. An access to way 0 sets 01 when way 1 is invalid and 10 otherwise. Fills and hits both count as accesses.
- R6: The way replaced on a read miss is way 0 for status 00 or 11 and way 1 for status 01 or 10. This is the least recently used valid way, or way 0 or way 1 when that way is still empty.
- R7: Every write produces exactly one memory write carrying the request's address and data. `cpu_done` follows in the cycle after `mem_ack`.
- R8: A write hit replaces the addressed word in the hitting way. A write miss allocates no line, so a later read of that address misses.
- R9: A one-cycle `inv_all` pulse sets every status code to 00, so every address misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | One-cycle pulse that invalidates every line |
| cpu_req | input | 1 | One-cycle request strobe from the core |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 27 | Byte address of the request |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 27 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The properties take for granted that `cpu_req` arrives only while the controller is idle, and that `mem_ack` is raised only while `mem_req` is high. They also assume `inv_all` never coincides with a request or with an outstanding line fill. The bench keeps to these conditions in three ways. It waits for `cpu_done` before starting each new access. Its memory model acknowledges only an open request, at most every other cycle. It pulses `inv_all` only between completed accesses.

// File: rtl/cache2w_pkg.sv
// Package: shared types and status-code helpers for the two-way cache.
// Assumes a 2-bit per-line status code that holds validity and recency together.
package cache2w_pkg;

    // Per-line status code shared by both ways
    typedef enum logic [1:0] {
        LS_EMPTY   = 2'b00,
        LS_ONLY_W0 = 2'b01,
        LS_W0_LAST = 2'b10,
        LS_W1_LAST = 2'b11
    } line_st_e;

    // Sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'b00,
        SQ_WRITE = 2'b01,
        SQ_FILL  = 2'b10
    } seq_st_e;

    // Way 0 is valid for every code except empty
    function automatic logic way0_valid(input logic [1:0] st);
        return st != LS_EMPTY;
    endfunction

    // Way 1 is valid only when both ways are valid
    function automatic logic way1_valid(input logic [1:0] st);
        return st[1];
    endfunction

    // Way to replace: an empty way first, otherwise the least recent one
    function automatic logic victim_way(input logic [1:0] st);
        return st[1] ^ st[0];
    endfunction

    // Code after an access (hit or fill) to the given way
    function automatic logic [1:0] st_after(input logic [1:0] st, input logic way);
        logic [1:0] nxt;
        if (way)
            nxt = LS_W1_LAST;
        else if (st[1])
            nxt = LS_W0_LAST;
        else
            nxt = LS_ONLY_W0;
        return nxt;
    endfunction

endpackage

// File: rtl/cache2w_tags.sv
// Tag and status store: one tag array per way and a shared status array.
// Assumes a single read index. Writes are applied at the clock edge.
// Invalidate has priority over a status write in the same cycle.
module cache2w_tags
    import cache2w_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             st_we,
    input  logic [1:0]       st_new,
    input  logic             tag_we,
    input  logic             tag_way,
    input  logic [TAG_W-1:0] tag_val,
    output logic [1:0]       st_cur,
    output logic [1:0]       hit
);
    localparam int LINES = 1 << IDX_W;

    logic [1:0] st_mem [LINES];

    // Status array: reset and invalidate clear every code; otherwise one line is updated
    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int i = 0; i < LINES; i++) st_mem[i] <= LS_EMPTY;
        end else if (st_we) begin
            st_mem[rd_idx] <= st_new;
        end
    end

    assign st_cur = st_mem[rd_idx];

    logic [1:0] valid;
    assign valid = {way1_valid(st_cur), way0_valid(st_cur)};

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [LINES];

        // Tag array for this way: written at the end of a line fill
        always_ff @(posedge clk) begin
            if (tag_we && (tag_way == 1'(w))) tag_mem[rd_idx] <= tag_val;
        end

        assign hit[w] = valid[w] && (tag_mem[rd_idx] == rd_tag);
    end

endmodule

// File: rtl/cache2w_data.sv
// Data store: four words per line per way, with no reset.
// Assumes a line write and a word write never target the same way in one cycle.
module cache2w_data #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        rd_word,
    input  logic              rd_way,
    output logic [DATA_W-1:0] rdata,
    input  logic              wd_we,
    input  logic              wd_way,
    input  logic [1:0]        wd_word,
    input  logic [DATA_W-1:0] wd_data,
    input  logic              ln_we,
    input  logic              ln_way,
    input  logic [4*DATA_W-1:0] ln_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 4;

    logic [DATA_W-1:0] way_word [2];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [DATA_W-1:0] dmem [LINES][WORDS];

        // Data array for this way: a whole line on a fill, a single word on a write hit
        always_ff @(posedge clk) begin
            if (ln_we && (ln_way == 1'(w))) begin
                for (int k = 0; k < WORDS; k++) dmem[idx][k] <= ln_data[k*DATA_W +: DATA_W];
            end else if (wd_we && (wd_way == 1'(w))) begin
                dmem[idx][wd_word] <= wd_data;
            end
        end

        assign way_word[w] = dmem[idx][rd_word];
    end

    assign rdata = rd_way ? way_word[1] : way_word[0];

endmodule

// File: rtl/cache2w_seq.sv
// Access sequencer: accepts core requests, does write-through, and runs line fills.
// Assumes a new request arrives only while idle, and mem_ack only while mem_req is high.
module cache2w_seq
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    input  logic [1:0]        hit,
    input  logic [1:0]        st_cur,
    input  logic [DATA_W-1:0] hit_word,
    output logic              busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              st_we,
    output logic [1:0]        st_new,
    output logic              fill_end,
    output logic              fill_way,
    output logic              wd_we,
    output logic [4*DATA_W-1:0] ln_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    seq_st_e           state;
    logic [1:0]        cnt;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] fbuf [3];
    logic              hit_any;
    logic              accept;

    assign hit_any  = |hit;
    assign accept   = (state == SQ_IDLE) && cpu_req;
    assign fill_end = (state == SQ_FILL) && mem_ack && (cnt == 2'd3);
    assign fill_way = victim_way(st_cur);

    // Main sequencer: latches requests, counts fill words, and produces the done pulse and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cnt       <= 2'd0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else begin
            cpu_done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (cpu_req) begin
                        lat_addr  <= cpu_addr;
                        lat_wdata <= cpu_wdata;
                        if (cpu_we) begin
                            state <= SQ_WRITE;
                        end else if (hit_any) begin
                            cpu_rdata <= hit_word;
                            cpu_done  <= 1'b1;
                        end else begin
                            state <= SQ_FILL;
                            cnt   <= 2'd0;
                        end
                    end
                end
                SQ_WRITE: begin
                    if (mem_ack) begin
                        cpu_done <= 1'b1;
                        state    <= SQ_IDLE;
                    end
                end
                SQ_FILL: begin
                    if (mem_ack) begin
                        cnt <= cnt + 2'd1;
                        if (cnt == 2'd3) begin
                            state     <= SQ_IDLE;
                            cpu_done  <= 1'b1;
                            cpu_rdata <= (lat_addr[3:2] == 2'd3) ? mem_rdata : fbuf[lat_addr[3:2]];
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Fill buffer: holds the first three words of a line until the last one arrives
    always_ff @(posedge clk) begin
        if ((state == SQ_FILL) && mem_ack && (cnt != 2'd3)) fbuf[cnt] <= mem_rdata;
    end

    // Status update: on a hit at acceptance, or on completion of a fill
    always_comb begin
        st_we  = (accept && hit_any) || fill_end;
        st_new = st_after(st_cur, (state == SQ_IDLE) ? hit[1] : fill_way);
    end

    assign wd_we   = accept && cpu_we && hit_any;
    assign ln_data = {mem_rdata, fbuf[2], fbuf[1], fbuf[0]};
    assign busy    = (state != SQ_IDLE);

    // Memory port: writes use the latched address; fills walk the words of the line
    always_comb begin
        mem_req   = busy;
        mem_we    = (state == SQ_WRITE);
        mem_wdata = lat_wdata;
        mem_addr  = (state == SQ_WRITE) ? lat_addr : {lat_addr[ADDR_W-1:4], cnt, 2'b00};
    end

endmodule

// File: rtl/cache2w_top.sv
// Two-way set-associative write-through cache controller, sized to 4KB or 2KB by SIZE_KB.
// Assumes one outstanding core request at a time and a word-per-ack memory port.
module cache2w_top #(
    parameter int SIZE_KB = 4,
    parameter int ADDR_W  = 27,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = 4;
    localparam int IDX_W = (SIZE_KB == 4) ? 7 : 6;
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic              seq_busy;
    logic [ADDR_W-1:0] lat_addr;
    logic [IDX_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic [1:0]        hit_vec;
    logic              hit_any;
    logic [1:0]        st_cur;
    logic              st_we;
    logic [1:0]        st_new;
    logic              fill_end;
    logic              fill_way;
    logic              wd_we;
    logic [4*DATA_W-1:0] ln_data;
    logic [DATA_W-1:0] hit_word;

    // Lookup address: the core's while idle, the latched one while busy
    always_comb begin
        rd_idx = seq_busy ? lat_addr[OFF_W +: IDX_W] : cpu_addr[OFF_W +: IDX_W];
        rd_tag = seq_busy ? lat_addr[ADDR_W-1 -: TAG_W] : cpu_addr[ADDR_W-1 -: TAG_W];
    end

    assign hit_any = |hit_vec;

    cache2w_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .inv_all (inv_all),
        .rd_idx  (rd_idx),
        .rd_tag  (rd_tag),
        .st_we   (st_we),
        .st_new  (st_new),
        .tag_we  (fill_end),
        .tag_way (fill_way),
        .tag_val (lat_addr[ADDR_W-1 -: TAG_W]),
        .st_cur  (st_cur),
        .hit     (hit_vec)
    );

    cache2w_data #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .idx     (rd_idx),
        .rd_word (cpu_addr[3:2]),
        .rd_way  (hit_vec[1]),
        .rdata   (hit_word),
        .wd_we   (wd_we),
        .wd_way  (hit_vec[1]),
        .wd_word (cpu_addr[3:2]),
        .wd_data (cpu_wdata),
        .ln_we   (fill_end),
        .ln_way  (fill_way),
        .ln_data (ln_data)
    );

    cache2w_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_done  (cpu_done),
        .hit       (hit_vec),
        .st_cur    (st_cur),
        .hit_word  (hit_word),
        .busy      (seq_busy),
        .lat_addr  (lat_addr),
        .st_we     (st_we),
        .st_new    (st_new),
        .fill_end  (fill_end),
        .fill_way  (fill_way),
        .wd_we     (wd_we),
        .ln_data   (ln_data),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/cache2w_chk.sv
// Protocol checker for the cache controller, bound to the top module.
// Assumes requests only while idle and acknowledges only while a request is open.
module cache2w_chk #(
    parameter int ADDR_W = 27,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              cpu_done,
    input logic              busy,
    input logic              hit_any,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    // R2: a read hit completes in the next cycle with no memory traffic
    p_read_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && !busy && hit_any |=> cpu_done && !mem_req);

    // R3: a read miss starts a line fetch at word 0 and does not complete at once
    p_fill_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && !busy && !hit_any |=> mem_req && !mem_we && !cpu_done && (mem_addr[3:0] == 4'd0));

    // R3: an open memory request holds its address and direction until acknowledged
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R3: fill words advance by one word after each acknowledge
    p_fill_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && (mem_addr[3:2] != 2'd3)
        |=> mem_req && (mem_addr[3:2] == $past(mem_addr[3:2]) + 2'd1));

    // R7: every write goes to memory with the request's address and data
    p_write_thru_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && !busy
        |=> mem_req && mem_we && (mem_addr == $past(cpu_addr)) && (mem_wdata == $past(cpu_wdata)));

endmodule

bind cache2w_top cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_done  (cpu_done),
    .busy      (seq_busy),
    .hit_any   (hit_any),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/cache2w_top_bench.sv
module cache2w_top_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [26:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done;
    logic        mem_req, mem_we;
    logic [26:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    cache2w_top #(.SIZE_KB(4)) u_cache2w_top (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [26:0] rd_log [4];
    logic [26:0] wr_addr = '0;
    logic [31:0] wr_data = '0;

    function automatic logic [31:0] pat(input logic [26:0] a);
        return {5'd0, a[26:2], 2'b01} ^ 32'hC3A5_0000;
    endfunction

    // Memory model: acknowledges an open request every other cycle, driven at the falling edge
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                wr_addr = mem_addr;
                wr_data = mem_wdata;
                wr_cnt  = wr_cnt + 1;
            end else begin
                mem_rdata = pat(mem_addr);
                if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [26:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd);
        int guard;
        rd_cnt    = 0;
        wr_cnt    = 0;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        guard = 0;
        while (!cpu_done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 200) check("R3 done-timeout", 32'd0, 32'd1);
        rd = cpu_rdata;
    endtask

    typedef struct packed {
        logic        we;
        logic [26:0] addr;
        logic [31:0] wdata;
        logic        use_pat;
        logic [31:0] exp;
        logic [2:0]  exp_rd;
        logic        exp_wr;
    } vec_t;

    localparam logic [26:0] A = 27'h000_0100;  // index 0x10, tag 0
    localparam logic [26:0] B = 27'h000_0900;  // index 0x10, tag 1
    localparam logic [26:0] C = 27'h000_1100;  // index 0x10, tag 2
    localparam logic [26:0] D = 27'h000_0500;  // index 0x50 (bit 10 set): R4
    localparam logic [26:0] E = 27'h004_0230;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, A,        32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R1 miss; 00->01 into way0
        '{1'b0, A+27'h4,  32'h0, 1'b1, 32'h0, 3'd0, 1'b0},  // R2 hit way0
        '{1'b0, B+27'h8,  32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R6 victim way1; 01->11
        '{1'b0, A+27'h8,  32'h0, 1'b1, 32'h0, 3'd0, 1'b0},  // R5 hit way0: 11->10
        '{1'b0, C+27'hC,  32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R6 victim way1 (B out); word3
        '{1'b0, A,        32'h0, 1'b1, 32'h0, 3'd0, 1'b0},  // R5 hit way0: 11->10
        '{1'b0, B,        32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R6 victim way1 (C out) -> 11
        '{1'b0, D+27'h4,  32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R4 other index
        '{1'b0, C,        32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R6 victim way0 (A out) -> 10
        '{1'b0, B+27'h4,  32'h0, 1'b1, 32'h0, 3'd0, 1'b0},  // R5 hit way1: 10->11
        '{1'b0, A,        32'h0, 1'b1, 32'h0, 3'd4, 1'b0},  // R6 victim way0 (C out) -> 10
        '{1'b0, D,        32'h0, 1'b1, 32'h0, 3'd0, 1'b0},  // R4 separate line kept
        '{1'b1, A+27'h4,  32'h1234_5678, 1'b0, 32'h0, 3'd0, 1'b1},  // R8 write hit
        '{1'b0, A+27'h4,  32'h0, 1'b0, 32'h1234_5678, 3'd0, 1'b0},  // R8 updated word
        '{1'b1, E,        32'hDEAD_BEEF, 1'b0, 32'h0, 3'd0, 1'b1},  // R8 write miss
        '{1'b0, E,        32'h0, 1'b1, 32'h0, 3'd4, 1'b0}   // R8 no allocate
    };

    initial begin
        #2ms;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 cpu_done", {31'd0, cpu_done}, 32'd0);
        check("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check("R1 cpu_rdata", cpu_rdata, 32'd0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].we, VEC[i].addr, VEC[i].wdata, rd);
            if (!VEC[i].we)
                check(VEC[i].exp_rd == 0 ? "R2 hit data" : "R3 fill data", rd,
                      VEC[i].use_pat ? pat(VEC[i].addr) : VEC[i].exp);
            check("R6 memory reads (hit/victim)", rd_cnt, 32'(VEC[i].exp_rd));
            check("R7 memory writes", wr_cnt, 32'(VEC[i].exp_wr));
            if (VEC[i].we) begin
                check("R7 write addr", {5'd0, wr_addr}, {5'd0, VEC[i].addr});
                check("R7 write data", wr_data, VEC[i].wdata);
            end
            if (VEC[i].exp_rd == 3'd4)
                for (int k = 0; k < 4; k++)
                    check("R3 word order", {5'd0, rd_log[k]},
                          {5'd0, VEC[i].addr[26:4], 2'(k), 2'b00});
        end

        // R9: invalidate empties the cache; lines that hit before now miss
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        access(1'b0, D, 32'h0, rd);
        check("R9 miss after invalidate", rd_cnt, 32'd4);
        check("R9 data after invalidate", rd, pat(D));
        access(1'b0, A+27'h4, 32'h0, rd);
        check("R9 written word dropped", rd, pat(A+27'h4));
        check("R9 refill reads", rd_cnt, 32'd4);
        // R5: after refill into way0 (00->01) a hit on the same line stays in way0
        access(1'b0, A+27'h8, 32'h0, rd);
        check("R5 hit after refill", rd_cnt, 32'd0);

        // R1: reset again clears the status, so a known line misses
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, A, 32'h0, rd);
        check("R1 miss after reset", rd_cnt, 32'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule